// File: doc/BRIEF.md
# CRC-Gated Receive Frame Buffer

This block sits on the receive path behind a serial line. It watches a 1-bit stream for a preamble followed by a start-of-frame delimiter. Once the delimiter has been seen, it packs the following bits into bytes and runs a CRC-32 over them. It also writes them into an on-chip frame buffer, where they stay hidden from the output until the frame is judged.

An end-of-frame strobe closes the frame. The block then compares the trailing four bytes with the CRC it has computed. On a match the frame is committed and drained through a valid/ready byte port, with a last flag on its final byte. On a mismatch, a too-short frame, or a frame that did not fit, the write pointer rolls back to the last commit point. The rejected bytes vanish, and frames accepted earlier but not yet read stay intact. A one-cycle good or bad strobe reports each verdict.

Top module: `rx_crc_gate`

## Requirements
- R1: Byte capture starts only after the 8 most recently received bits, taken LSB first, equal 0xD5. A stream of 0x55 and 0x00 bytes with no such pattern produces no frame, no strobe and no output.
- R2: While a frame is open, each run of 8 bits with `bit_valid_i` high forms one byte, with the first bit received in bit 0.
- R3: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, processed LSB first as 0xEDB88320, initial value all ones, result inverted). It covers every byte except the last four. The last four bytes carry the CRC, least significant byte first. When they match, `frame_good_o` pulses for one cycle two cycles after `eof_i`, and the payload bytes become available at the output in order.
- R4: On a CRC mismatch, `frame_bad_o` pulses in the same cycle that a good frame would pulse `frame_good_o`, and none of that frame's bytes ever appear at the output.
- R5: Released bytes keep their order. `out_last_o` is high only on the final payload byte of each frame. While `out_valid_o` is high and `out_ready_i` is low, the data, the last flag and the valid signal hold steady.
- R6: Rejecting a frame leaves every previously accepted frame in the buffer intact, including frames not yet read.
- R7: A frame whose payload exceeds the free buffer space at the time it is written is reported bad and discarded. A payload that exactly fills the free space is accepted.
- R8: A frame of fewer than five bytes after the delimiter is reported bad.
- R9: `eof_i` outside a frame has no effect. Inside a frame, `eof_i` takes priority over a bit in the same cycle. Trailing bits that do not complete a byte are dropped and do not affect the verdict.
- R10: After reset, `out_valid_o`, `frame_good_o` and `frame_bad_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | `bit_i` carries a bit this cycle |
| eof_i | input | 1 | End-of-frame strobe |
| out_data_o | output | 8 | Released payload byte |
| out_valid_o | output | 1 | `out_data_o` is valid |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_last_o | output | 1 | Final byte of a released frame |
| frame_good_o | output | 1 | One-cycle pulse: frame accepted |
| frame_bad_o | output | 1 | One-cycle pulse: frame rejected |

## Verification
The bench builds the block with a 32-byte buffer. This lets every payload length from 1 to 32 be swept and the exact-fit and one-byte-over cases be reached with a handful of frames. With the output stalled, several frames can be stacked behind a rejected one to show that rollback stops at the commit point. Corrupted CRC bytes, corrupted payload bytes, truncated frames, trailing partial bits and idle end-of-frame strobes are each swept over a range of lengths. The output is throttled to two cycles in three, which exercises the hold behaviour on every stall.

// File: rtl/rx_crc_gate_pkg.sv
package rx_crc_gate_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam int unsigned TAIL_N   = 4;

  // reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crc32_next(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rx_deser.sv
module rx_deser
  import rx_crc_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_valid_i,
  input  logic       eof_i,
  output logic       sof_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       eof_o
);
  logic [7:0] sr_q;
  logic [2:0] cnt_q;
  logic       in_frame_q;
  logic [7:0] sr_nxt;

  assign sr_nxt = {bit_i, sr_q[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      sof_o      <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      eof_o      <= 1'b0;
    end else begin
      sof_o      <= 1'b0;
      byte_vld_o <= 1'b0;
      eof_o      <= 1'b0;
      if (in_frame_q && eof_i) begin
        // eof wins over a same-cycle bit; partial byte dropped
        in_frame_q <= 1'b0;
        eof_o      <= 1'b1;
        cnt_q      <= '0;
        sr_q       <= '0;
      end else if (bit_valid_i) begin
        sr_q <= sr_nxt;
        if (!in_frame_q) begin
          if (sr_nxt == SFD_BYTE) begin
            in_frame_q <= 1'b1;
            sof_o      <= 1'b1;
            cnt_q      <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            byte_vld_o <= 1'b1;
            byte_o     <= sr_nxt;
          end
        end
      end
    end
  end

  // R2
  byte_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> in_frame_q);
endmodule

// File: rtl/rx_crc32.sv
module rx_crc32
  import rx_crc_gate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_INIT;
    else if (clr_i)  crc_o <= CRC_INIT;
    else if (en_i)   crc_o <= crc32_next(crc_o, byte_i);
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int unsigned DEPTH = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] data_i,
  input  logic       commit_i,
  input  logic       rollback_i,
  output logic       full_o,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  output logic       out_last_o,
  input  logic       out_ready_i
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [7:0]    dat_mem [DEPTH];
  logic          last_mem[DEPTH];
  logic [PW-1:0] wr_q, cm_q, rd_q;
  logic [AW-1:0] last_idx;
  logic          do_push, do_pop;

  assign full_o      = (wr_q - rd_q) == PW'(DEPTH);
  assign do_push     = push_i && !full_o;
  assign out_valid_o = rd_q != cm_q;
  assign do_pop      = out_valid_o && out_ready_i;
  assign last_idx    = wr_q[AW-1:0] - AW'(1);
  assign out_data_o  = dat_mem[rd_q[AW-1:0]];
  assign out_last_o  = last_mem[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      dat_mem[wr_q[AW-1:0]]  <= data_i;
      last_mem[wr_q[AW-1:0]] <= 1'b0;
    end else if (commit_i) begin
      last_mem[last_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      cm_q <= '0;
      rd_q <= '0;
    end else begin
      if (rollback_i)   wr_q <= cm_q;
      else if (do_push) wr_q <= wr_q + PW'(1);
      if (commit_i)     cm_q <= wr_q;
      if (do_pop)       rd_q <= rd_q + PW'(1);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q - rd_q) <= PW'(DEPTH));
  // R6
  commit_behind_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_q - rd_q) <= (wr_q - rd_q));
  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
endmodule

// File: rtl/rx_crc_gate.sv
module rx_crc_gate
  import rx_crc_gate_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_valid_i,
  input  logic       eof_i,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic       out_last_o,
  output logic       frame_good_o,
  output logic       frame_bad_o
);
  localparam logic [2:0] TAIL = 3'(TAIL_N);

  logic        sof, byte_vld, eof_int, full, push, pass;
  logic [7:0]  byte_d;
  logic [7:0]  hold_q [TAIL_N];
  logic [2:0]  hcnt_q;
  logic        ovf_q, body_q;
  logic [31:0] crc_q;

  rx_deser i_deser (
    .clk_i, .rst_ni, .bit_i, .bit_valid_i, .eof_i,
    .sof_o(sof), .byte_vld_o(byte_vld), .byte_o(byte_d), .eof_o(eof_int)
  );

  // tail bytes are held back until a newer byte proves they are payload
  assign push = byte_vld && (hcnt_q == TAIL);

  rx_crc32 i_crc (
    .clk_i, .rst_ni, .clr_i(sof), .en_i(push), .byte_i(hold_q[0]), .crc_o(crc_q)
  );

  assign pass = body_q && !ovf_q && (hcnt_q == TAIL) &&
                (~crc_q == {hold_q[3], hold_q[2], hold_q[1], hold_q[0]});

  rx_frame_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(hold_q[0]),
    .commit_i(eof_int && pass), .rollback_i(eof_int && !pass),
    .full_o(full),
    .out_data_o, .out_valid_o, .out_last_o, .out_ready_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAIL_N; i++) hold_q[i] <= '0;
      hcnt_q       <= '0;
      ovf_q        <= 1'b0;
      body_q       <= 1'b0;
      frame_good_o <= 1'b0;
      frame_bad_o  <= 1'b0;
    end else begin
      frame_good_o <= eof_int && pass;
      frame_bad_o  <= eof_int && !pass;
      if (sof) begin
        hcnt_q <= '0;
        ovf_q  <= 1'b0;
        body_q <= 1'b0;
      end else if (byte_vld) begin
        if (hcnt_q != TAIL) begin
          hold_q[hcnt_q[1:0]] <= byte_d;
          hcnt_q              <= hcnt_q + 3'd1;
        end else begin
          for (int i = 0; i < TAIL_N - 1; i++) hold_q[i] <= hold_q[i+1];
          hold_q[TAIL_N-1] <= byte_d;
          body_q           <= 1'b1;
          if (full) ovf_q <= 1'b1;
        end
      end
    end
  end

  // R3
  good_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_good_o |-> out_valid_o);
  // R8
  short_frame_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_int && (hcnt_q != TAIL)) |=> frame_bad_o);
endmodule

// File: tb/test_rx_crc_gate.sv
module test_rx_crc_gate;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0, bit_valid_i = 1'b0, eof_i = 1'b0;
  logic rdy = 1'b0;
  logic [7:0] out_data_o;
  logic out_valid_o, out_last_o, frame_good_o, frame_bad_o;

  int n_chk = 0, n_fail = 0, n_good = 0, n_bad = 0, cyc = 0, bit_cnt = 0;
  bit hold_rdy = 1'b0, gap_en = 1'b0;
  logic [8:0] exp_q[$];
  logic [7:0] frm [0:63];
  logic pv = 1'b0, prdy = 1'b0, pl = 1'b0;
  logic [7:0] pd = '0;

  always #5 clk_i = ~clk_i;

  rx_crc_gate #(.DEPTH(32)) i_rx_crc_gate (
    .clk_i, .rst_ni, .bit_i, .bit_valid_i, .eof_i,
    .out_data_o, .out_valid_o, .out_ready_i(rdy), .out_last_o,
    .frame_good_o, .frame_bad_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (frame_good_o) n_good++;
      if (frame_bad_o)  n_bad++;
      rdy = !hold_rdy && (cyc % 3 != 0);
      if (pv && !prdy)  // R5 hold while stalled
        chk(out_valid_o && out_data_o == pd && out_last_o == pl, "R5 stall hold",
            {23'd0, out_valid_o, out_data_o}, {23'd0, 1'b1, pd});
      if (out_valid_o && rdy) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {24'd0, out_data_o}, 32'hFFFF);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_last_o, out_data_o} == e, "R3 R5 released byte",
              {23'd0, out_last_o, out_data_o}, {23'd0, e});
        end
      end
      pv = out_valid_o; prdy = rdy; pd = out_data_o; pl = out_last_o;
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ frm[i][k];
        c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
      end
    return ~c;
  endfunction

  task automatic step(input logic b, input logic v, input logic e);
    @(posedge clk_i); #1;
    bit_i = b; bit_valid_i = v; eof_i = e;
  endtask

  task automatic send_bit(input logic b);
    if (gap_en && (bit_cnt % 7 == 3)) step(1'b0, 1'b0, 1'b0);
    step(b, 1'b1, 1'b0);
    bit_cnt++;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) send_bit(b[k]);  // R2 LSB first
  endtask

  task automatic idle(input int n);
    repeat (n) step(1'b0, 1'b0, 1'b0);
  endtask

  // mode 0 clean, 1 bad crc byte, 2 bad payload bit, 3 trailing bits + eof with bit, 4 raw n bytes only
  task automatic send_frame(input int n, input int mode, input bit exp_good, input string req);
    logic [31:0] c;
    int g0, b0, tot;
    for (int i = 0; i < n; i++) frm[i] = 8'((n * 29 + i * 13 + 7) & 255);
    tot = n;
    if (mode != 4) begin
      c = ref_crc(n);
      frm[n] = c[7:0]; frm[n+1] = c[15:8]; frm[n+2] = c[23:16]; frm[n+3] = c[31:24];
      tot = n + 4;
      if (mode == 1) frm[n + (n % 4)] ^= 8'(1 << (n % 8));
      if (mode == 2) frm[(n * 5) % n] ^= 8'(8'h80 >> (n % 8));
    end
    if (exp_good)
      for (int i = 0; i < n; i++) exp_q.push_back({(i == n - 1), frm[i]});
    repeat (3) send_byte(8'h55);
    send_byte(8'hD5);
    for (int i = 0; i < tot; i++) send_byte(frm[i]);
    g0 = n_good; b0 = n_bad;
    if (mode == 3) begin
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      step(1'b1, 1'b1, 1'b1);  // R9 eof beats bit
    end else step(1'b0, 1'b0, 1'b1);
    idle(5);
    chk(n_good == g0 + int'(exp_good), {req, " good pulse"}, n_good - g0, int'(exp_good));
    chk(n_bad == b0 + int'(!exp_good), {req, " bad pulse"}, n_bad - b0, int'(!exp_good));
  endtask

  task automatic drain(input string req);
    hold_rdy = 1'b0;
    for (int t = 0; t < 3000 && exp_q.size() > 0; t++) @(posedge clk_i);
    idle(4);
    chk(exp_q.size() == 0, {req, " all expected released"}, exp_q.size(), 0);
    @(negedge clk_i);
    chk(!out_valid_o, {req, " nothing extra"}, out_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g0, b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10
    chk(!out_valid_o && !frame_good_o && !frame_bad_o, "R10 reset outputs",
        {out_valid_o, frame_good_o, frame_bad_o}, 0);
    #1 rst_ni = 1'b1;
    idle(2);

    // R9 eof while idle
    g0 = n_good; b0 = n_bad;
    step(1'b0, 1'b0, 1'b1); idle(5);
    chk(n_good == g0 && n_bad == b0 && !out_valid_o, "R9 idle eof ignored", n_good + n_bad, g0 + b0);

    // R1 no delimiter, no frame
    repeat (2) send_byte(8'h00);
    repeat (6) send_byte(8'h55);
    step(1'b0, 1'b0, 1'b1); idle(5);
    chk(n_good == g0 && n_bad == b0 && !out_valid_o, "R1 no delimiter", n_good + n_bad, g0 + b0);

    // R3 length sweep
    for (int n = 1; n <= 31; n++) begin
      gap_en = n[0];
      send_frame(n, 0, 1'b1, "R3");
    end
    drain("R3");
    send_frame(32, 0, 1'b1, "R3");
    drain("R3");

    // R4 corrupted crc / payload
    for (int n = 1; n <= 12; n++) send_frame(n, 1, 1'b0, "R4");
    for (int n = 1; n <= 12; n++) send_frame(n, 2, 1'b0, "R4");
    drain("R4");

    // R9 trailing bits
    send_frame(5, 3, 1'b1, "R9");
    send_frame(9, 3, 1'b1, "R9");
    drain("R9");

    // R8 short frames
    for (int k = 0; k <= 4; k++) send_frame(k, 4, 1'b0, "R8");
    drain("R8");

    // R7 overflow and exact fit
    hold_rdy = 1'b1;
    send_frame(33, 0, 1'b0, "R7");
    send_frame(32, 0, 1'b1, "R7");
    drain("R7");

    // R6 rollback keeps committed frames
    hold_rdy = 1'b1;
    send_frame(10, 0, 1'b1, "R6");
    send_frame(10, 1, 1'b0, "R6");
    send_frame(20, 0, 1'b1, "R6");
    send_frame(3, 0, 1'b0, "R7");
    send_frame(2, 0, 1'b1, "R7");
    drain("R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule